// File: doc/BRIEF.md
# Quadrature Decoder With Index Logic

This block sits between the pins of an incremental encoder and a position counter. It takes the two phase inputs and the index input, cleans them with a digital filter, and turns them into a one-cycle count-enable pulse with a direction bit. A separate pulse asks the counter to load its preset. The counter datapath lives outside this block.

The decoder has four modes. In pulse/direction mode, one input is the count pulse and the other gives the direction. The three quadrature modes take one, two or four counts per encoder cycle. A programmable divider sets the sampling rate of the filter. Two abnormal events, an input pair that changes in the same filter sample or a moving input while the decoder is disabled, are handled as described below. An illegal quadrature jump raises a sticky noise flag, which stays set until it is explicitly cleared. The index can act in two ways. It can load the preset on its edge, with the polarity selectable. In the quadrature modes it can instead be qualified by the phase state.

Top module: `quad_index_decoder`

## Requirements
- R1: After reset, cnt_en, preset_load and noise_err are 0 and cnt_up is 1. The filter divider is 0, so the filter samples on every clock.
- R2: The mode value 0 selects pulse/direction mode. A count happens on each rising edge of filtered A, and cnt_up equals filtered B at that edge (1 = up). Edges of B never count.
- R3: Mode 3 (x4) counts every single edge of A or of B. The state {A,B} moving 00→01→11→10→00 counts up, and the reverse order counts down.
- R4: Mode 2 (x2) counts every edge of A, with the direction given by the R3 sequence. Edges of B do not count.
- R5: Mode 1 (x1) counts a rising A edge only when it moves forward and a falling A edge only when it moves backward. All other edges do not count.
- R6: A filtered input takes a new value only after two consecutive filter samples have agreed on it. With the divider at 0, a raw change gives its cnt_en pulse in the third clock after the change. A one-clock glitch gives no pulse.
- R7: A psc_load strobe loads psc_value into the divider, and the filter then samples once every psc_value+1 clocks. With a value of 3, a raw A change gives its pulse in the ninth clock after the load.
- R8: In modes 1 to 3, a change of A and B in the same filter sample sets noise_err and gives no count. The flag stays set until err_clr is applied. In mode 0, the same change raises no error.
- R9: While ab_en is 0, no count pulse occurs and noise_err is not set.
- R10: With idx_sync off, an index edge of the selected polarity produces a preset_load pulse when preset_ld_n is 0. A rising edge is selected when idx_pol is 1 and a falling edge when it is 0. No pulse occurs while preset_ld_n is 1, and changing idx_pol is not an edge.
- R11: With idx_sync on in modes 1 to 3, preset_load pulses when filtered {A,B} enters 00 while the index is at its active level. An index edge alone does not load. In mode 0, idx_sync is ignored and R10 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Phase A, or the count pulse in mode 0 (synchronous to clk) |
| in_b | input | 1 | Phase B, or the direction in mode 0 |
| in_idx | input | 1 | Index input |
| mode | input | 2 | Decode mode: 0 pulse/dir, 1 x1, 2 x2, 3 x4 |
| ab_en | input | 1 | Count enable for A/B |
| idx_sync | input | 1 | Qualify the index with the phase state |
| idx_pol | input | 1 | Index active level, 1 = high |
| preset_ld_n | input | 1 | Active-low enable of the index preset load |
| psc_load | input | 1 | Strobe that loads psc_value into the filter divider |
| psc_value | input | PSC_W (8) | New filter divider value |
| err_clr | input | 1 | Clears noise_err |
| cnt_en | output | 1 | One-cycle count pulse |
| cnt_up | output | 1 | Direction of the latest count, 1 = up |
| preset_load | output | 1 | One-cycle request to load the preset |
| noise_err | output | 1 | Sticky illegal-transition flag |

## Verification
A stale previous-phase register or a wrong direction term shows up as a missing, extra or reversed count pulse exactly three clocks after the offending input change. A wrong divider or filter history moves that pulse to a different cycle, so each check samples one precise cycle and does not look at a window. A broken index edge memory or a broken phase-state memory shows up as a preset_load pulse that is missing or spurious, in the same cycle as the counts.

// File: rtl/qd_pkg.sv
package qd_pkg;
   typedef enum logic [1:0] {
      QD_PULSE_DIR = 2'd0,
      QD_X1        = 2'd1,
      QD_X2        = 2'd2,
      QD_X4        = 2'd3
   } qd_mode_e;
endpackage

// File: rtl/qd_tick.sv
// Filter sample strobe: high once every (div_q + 1) clocks.
module qd_tick #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PSC_W-1:0] value,
   output logic             tick
);
   logic [PSC_W-1:0] div_q, cnt_q;

   assign tick = (cnt_q == div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         div_q <= value;
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/qd_filter.sv
// Accepts a raw level once STABLE_N consecutive samples agree on it.
module qd_filter #(
   parameter int STABLE_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw,
   output logic clean
);
   localparam int HW = STABLE_N - 1;

   logic [HW-1:0] hist_q, hist_d;
   logic          agree;

   generate
      if (HW == 1) begin : g_one
         assign hist_d = raw;
      end else begin : g_many
         assign hist_d = {hist_q[HW-2:0], raw};
      end
   endgenerate

   assign agree = (hist_q == {HW{raw}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         clean  <= 1'b0;
      end else if (tick) begin
         hist_q <= hist_d;
         if (agree) clean <= raw;
      end
   end
endmodule

// File: rtl/qd_decode.sv
// Phase decoder: count pulse, direction and illegal-jump flag.
module qd_decode
   import qd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fa,
   input  logic     fb,
   input  qd_mode_e mode,
   input  logic     ab_en,
   input  logic     err_clr,
   output logic     cnt_en,
   output logic     cnt_up,
   output logic     noise_err
);
   logic pa_q, pb_q;
   logic da, db, up_a, up_b, hit, dir, bad;

   assign da   = fa ^ pa_q;
   assign db   = fb ^ pb_q;
   assign up_a = ~(fa ^ fb);   // forward when A moves to match B
   assign up_b = fa ^ fb;      // forward when B moves away from A
   assign bad  = ab_en & (mode != QD_PULSE_DIR) & da & db;

   always_comb begin
      hit = 1'b0;
      dir = cnt_up;
      unique case (mode)
         QD_PULSE_DIR: if (da && fa) begin
            hit = 1'b1;
            dir = fb;
         end
         QD_X1: if (da && !db) begin
            if (fa && up_a) begin
               hit = 1'b1;
               dir = 1'b1;
            end else if (!fa && !up_a) begin
               hit = 1'b1;
               dir = 1'b0;
            end
         end
         QD_X2: if (da && !db) begin
            hit = 1'b1;
            dir = up_a;
         end
         QD_X4: if (da ^ db) begin
            hit = 1'b1;
            dir = da ? up_a : up_b;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_q      <= 1'b0;
         pb_q      <= 1'b0;
         cnt_en    <= 1'b0;
         cnt_up    <= 1'b1;
         noise_err <= 1'b0;
      end else begin
         pa_q   <= fa;
         pb_q   <= fb;
         cnt_en <= ab_en & hit;
         if (ab_en && hit) cnt_up <= dir;
         if (bad)          noise_err <= 1'b1;
         else if (err_clr) noise_err <= 1'b0;
      end
   end
endmodule

// File: rtl/qd_index.sv
// Index handling: polarity edge load, or load qualified by phase state 00.
module qd_index (
   input  logic clk,
   input  logic rst_n,
   input  logic fi,
   input  logic fa,
   input  logic fb,
   input  logic quad,
   input  logic sync_req,
   input  logic pol,
   input  logic load_n,
   output logic preset_load
);
   logic pi_q, zero_q;
   logic edge_hit, active, ab_zero, enter_zero, fire;

   assign edge_hit   = pol ? (fi & ~pi_q) : (~fi & pi_q);
   assign active     = pol ? fi : ~fi;
   assign ab_zero    = ~fa & ~fb;
   assign enter_zero = ab_zero & ~zero_q;
   assign fire = ~load_n & ((sync_req & quad) ? (active & enter_zero) : edge_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pi_q        <= 1'b0;
         zero_q      <= 1'b1;
         preset_load <= 1'b0;
      end else begin
         pi_q        <= fi;
         zero_q      <= ab_zero;
         preset_load <= fire;
      end
   end
endmodule

// File: rtl/quad_index_decoder.sv
module quad_index_decoder
   import qd_pkg::*;
#(
   parameter int PSC_W    = 8,
   parameter int STABLE_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_a,
   input  logic             in_b,
   input  logic             in_idx,
   input  logic [1:0]       mode,
   input  logic             ab_en,
   input  logic             idx_sync,
   input  logic             idx_pol,
   input  logic             preset_ld_n,
   input  logic             psc_load,
   input  logic [PSC_W-1:0] psc_value,
   input  logic             err_clr,
   output logic             cnt_en,
   output logic             cnt_up,
   output logic             preset_load,
   output logic             noise_err
);
   localparam int N_IN = 3;

   generate
      if (PSC_W < 1 || PSC_W > 16) begin : g_bad_psc
         $error("PSC_W must lie in 1..16");
      end
      if (STABLE_N < 2 || STABLE_N > 8) begin : g_bad_stable
         $error("STABLE_N must lie in 2..8");
      end
   endgenerate

   logic            filt_tick;
   logic [N_IN-1:0] raw_vec, clean_vec;
   qd_mode_e        mode_e;

   assign raw_vec = {in_idx, in_b, in_a};
   assign mode_e  = qd_mode_e'(mode);

   qd_tick #(.PSC_W(PSC_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .load(psc_load), .value(psc_value), .tick(filt_tick)
   );

   for (genvar g = 0; g < N_IN; g++) begin : g_filt
      qd_filter #(.STABLE_N(STABLE_N)) u_f (
         .clk(clk), .rst_n(rst_n), .tick(filt_tick),
         .raw(raw_vec[g]), .clean(clean_vec[g])
      );
   end

   qd_decode u_dec (
      .clk(clk), .rst_n(rst_n), .fa(clean_vec[0]), .fb(clean_vec[1]),
      .mode(mode_e), .ab_en(ab_en), .err_clr(err_clr),
      .cnt_en(cnt_en), .cnt_up(cnt_up), .noise_err(noise_err)
   );

   qd_index u_idx (
      .clk(clk), .rst_n(rst_n), .fi(clean_vec[2]), .fa(clean_vec[0]),
      .fb(clean_vec[1]), .quad(mode_e != QD_PULSE_DIR), .sync_req(idx_sync),
      .pol(idx_pol), .load_n(preset_ld_n), .preset_load(preset_load)
   );
endmodule

// File: rtl/qd_checker.sv
module qd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       ab_en,
   input logic       preset_ld_n,
   input logic       err_clr,
   input logic       cnt_en,
   input logic       noise_err,
   input logic       preset_load
);
   // R9
   a_r9_disabled_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      !ab_en |=> !cnt_en);
   // R8
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (noise_err && !err_clr) |=> noise_err);
   // R8, R9
   a_r8_err_quad_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(noise_err) |-> ($past(mode) != 2'd0 && $past(ab_en)));
   // R10, R11
   a_r10_load_gated: assert property (@(posedge clk) disable iff (!rst_n)
      preset_load |-> !$past(preset_ld_n));
   // R2
   a_r2_pd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && $past(mode) == 2'd0 && mode == 2'd0) |=> !cnt_en);
endmodule

bind quad_index_decoder qd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .ab_en(ab_en),
   .preset_ld_n(preset_ld_n), .err_clr(err_clr), .cnt_en(cnt_en),
   .noise_err(noise_err), .preset_load(preset_load)
);

// File: tb/sim_quad_index_decoder.sv
`timescale 1ns/1ps
module sim_quad_index_decoder;
   logic clk = 1'b0, rst_n = 1'b0;
   logic in_a = 0, in_b = 0, in_idx = 0, ab_en = 1, idx_sync = 0, idx_pol = 1;
   logic preset_ld_n = 1, psc_load = 0, err_clr = 0;
   logic [1:0] mode = 2'd3;
   logic [7:0] psc_value = 8'd0;
   logic cnt_en, cnt_up, preset_load, noise_err;
   int   n_chk = 0, n_bad = 0;
   bit   done = 0;
   logic s_en, s_up, s_ld, s_err;

   always #4 clk = ~clk;

   quad_index_decoder u0 (
      .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
      .mode(mode), .ab_en(ab_en), .idx_sync(idx_sync), .idx_pol(idx_pol),
      .preset_ld_n(preset_ld_n), .psc_load(psc_load), .psc_value(psc_value),
      .err_clr(err_clr), .cnt_en(cnt_en), .cnt_up(cnt_up),
      .preset_load(preset_load), .noise_err(noise_err)
   );

   // {mode[1:0], a, b, expected cnt_en, expected cnt_up}
   localparam logic [5:0] VEC [0:27] = '{
      6'b11_01_11, 6'b11_11_11, 6'b11_10_11, 6'b11_00_11,
      6'b11_10_10, 6'b11_11_10, 6'b11_01_10, 6'b11_00_10,
      6'b10_01_00, 6'b10_11_11, 6'b10_10_00, 6'b10_00_11,
      6'b10_10_10, 6'b10_00_11,
      6'b01_01_00, 6'b01_11_11, 6'b01_10_00, 6'b01_00_00,
      6'b01_10_00, 6'b01_11_00, 6'b01_01_10, 6'b01_00_00,
      6'b00_01_00, 6'b00_11_11, 6'b00_01_00, 6'b00_00_00,
      6'b00_10_10, 6'b00_00_00
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at a negedge, sample in the negedge after the third rising edge
   task automatic step(input logic [1:0] m, input logic a, input logic b, input logic i);
      @(negedge clk);
      mode = m; in_a = a; in_b = b; in_idx = i;
      repeat (3) @(posedge clk);
      @(negedge clk);
      s_en = cnt_en; s_up = cnt_up; s_ld = preset_load; s_err = noise_err;
      repeat (2) @(negedge clk);
   endtask

   function automatic string tag(input logic [1:0] m);
      case (m)
         2'd0: return "R2 pulse/dir";
         2'd1: return "R5 x1";
         2'd2: return "R4 x2";
         default: return "R3 x4";
      endcase
   endfunction

   initial begin
      int pulses;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cnt_en", cnt_en, 0);
      chk("R1 preset_load", preset_load, 0);
      chk("R1 noise_err", noise_err, 0);
      chk("R1 cnt_up", cnt_up, 1);
      rst_n = 1'b1;

      for (int k = 0; k < 28; k++) begin
         step(VEC[k][5:4], VEC[k][3], VEC[k][2], 1'b0);
         chk({tag(VEC[k][5:4]), " count"}, s_en, VEC[k][1]);
         if (VEC[k][1]) chk({tag(VEC[k][5:4]), " dir"}, s_up, VEC[k][0]);
      end

      // R9 disabled: no count, no error
      ab_en = 0;
      step(2'd3, 1, 0, 0); chk("R9 no count", s_en, 0);
      step(2'd3, 0, 1, 0); chk("R9 no error on jump", s_err, 0);
      step(2'd3, 0, 0, 0);
      ab_en = 1;

      // R8 illegal jump in x4
      step(2'd3, 1, 1, 0);
      chk("R8 no count on jump", s_en, 0);
      chk("R8 error set", s_err, 1);
      repeat (5) @(negedge clk);
      chk("R8 error sticky", noise_err, 1);
      err_clr = 1; @(negedge clk); err_clr = 0;
      chk("R8 error cleared", noise_err, 0);
      step(2'd3, 0, 1, 0);
      step(2'd3, 0, 0, 0);
      // R8 / R2 same jump in pulse/dir mode
      step(2'd0, 1, 1, 0);
      chk("R8 no error in pulse/dir", s_err, 0);
      chk("R2 count on A rise with B", s_en, 1);
      chk("R2 dir up", s_up, 1);
      step(2'd0, 0, 0, 0);

      // R6 glitch of one clock
      @(negedge clk); mode = 2'd3; in_a = 1;
      @(negedge clk); in_a = 0;
      pulses = 0;
      repeat (6) begin @(negedge clk); pulses += int'(cnt_en); end
      chk("R6 glitch ignored", pulses, 0);
      // R6 latency
      @(negedge clk); in_a = 1;
      repeat (2) @(posedge clk); @(negedge clk);
      chk("R6 not before third clock", cnt_en, 0);
      @(posedge clk); @(negedge clk);
      chk("R6 pulse in third clock", cnt_en, 1);
      step(2'd3, 0, 0, 0);

      // R7 divider of 3
      @(negedge clk); psc_value = 8'd3; psc_load = 1;
      @(negedge clk); psc_load = 0; in_a = 1;
      repeat (8) @(posedge clk); @(negedge clk);
      chk("R7 no pulse before ninth clock", cnt_en, 0);
      @(posedge clk); @(negedge clk);
      chk("R7 pulse in ninth clock", cnt_en, 1);
      @(negedge clk); psc_value = 8'd0; psc_load = 1;
      @(negedge clk); psc_load = 0;
      step(2'd3, 0, 0, 0);

      // R10 edge load
      idx_pol = 1; preset_ld_n = 0; idx_sync = 0;
      step(2'd3, 0, 0, 1); chk("R10 rising load", s_ld, 1);
      step(2'd3, 0, 0, 0); chk("R10 falling ignored", s_ld, 0);
      preset_ld_n = 1;
      step(2'd3, 0, 0, 1); chk("R10 load disabled", s_ld, 0);
      step(2'd3, 0, 0, 0);
      preset_ld_n = 0;
      @(negedge clk); idx_pol = 0;
      pulses = 0;
      repeat (5) begin @(negedge clk); pulses += int'(preset_load); end
      chk("R10 polarity change no load", pulses, 0);
      step(2'd3, 0, 0, 1); chk("R10 rising ignored neg pol", s_ld, 0);
      step(2'd3, 0, 0, 0); chk("R10 falling load neg pol", s_ld, 1);

      // R11 synchronous index
      idx_pol = 1; idx_sync = 1;
      step(2'd3, 0, 0, 1); chk("R11 edge alone no load", s_ld, 0);
      step(2'd3, 0, 1, 1); chk("R11 leaving 00 no load", s_ld, 0);
      step(2'd3, 0, 0, 1); chk("R11 enter 00 active load", s_ld, 1);
      step(2'd3, 0, 0, 0);
      step(2'd3, 0, 1, 0);
      step(2'd3, 0, 0, 0); chk("R11 enter 00 inactive no load", s_ld, 0);
      step(2'd0, 0, 0, 1); chk("R11 sync ignored in pulse/dir", s_ld, 1);
      step(2'd0, 0, 0, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule